// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken by running two direction predictors side by side and letting a third table decide which one to trust. The first predictor hashes a shift register of recent branch outcomes from the whole program with the branch address. The second keeps a short outcome history for each branch address and uses that history to pick a counter. A table of 2-bit selector counters, one for each branch address, tracks which of the two has been right more often for that branch. The selector's verdict decides which prediction is driven out.

A fetch stage presents the low bits of a branch address on the lookup port. In the same cycle it receives the final direction and both component directions. When the branch resolves, the pipeline returns the address, the real outcome and the two component directions it saw at lookup. On that update both component predictors train and both histories shift in the outcome, whichever component was selected. The selector moves toward a component only when that component alone was right. The caller supplies just the low address bits that index the tables. Branch targets and more than one branch per cycle are not handled.

Top module: `tourney_pred`

## Requirements
- R1: After reset every component counter holds 2'b01 (weakly not taken), every selector holds 2'b10 (weakly prefers the global component), and both history kinds hold zero, so every lookup returns 0 on all three prediction outputs.
- R2: Component counters are 2-bit saturating: an update with outcome taken adds one up to 3, not taken subtracts one down to 0, and a counter predicts taken when its value is 2 or 3.
- R3: The global component indexes its counter table with (global history XOR address), and every update shifts the outcome into bit 0 of the global history, dropping the oldest bit.
- R4: The local component reads a per-address history register selected by the address, and that history indexes a separate counter table. On update the outcome shifts into bit 0 of that address's history.
- R5: The selector counter for the looked-up address picks the output: values 2 and 3 drive the global prediction, values 0 and 1 drive the local prediction.
- R6: On update the selector for that address increments, saturating at 3, when only the returned global prediction matched the outcome. It decrements, saturating at 0, when only the local one matched. It holds when both or neither matched.
- R7: Every update trains both component tables and both histories regardless of the selector value, and a cycle with `up_valid` low changes no state.
- R8: Lookup is combinational from current state, and the effect of an update is visible on lookups from the cycle after the update's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_pc | input | PC_W | Low branch-address bits for lookup |
| lk_final | output | 1 | Selected direction, 1 = taken |
| lk_gpred | output | 1 | Global component direction |
| lk_lpred | output | 1 | Local component direction |
| up_valid | input | 1 | A resolved branch is being reported this cycle |
| up_pc | input | PC_W | Low branch-address bits of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_gpred | input | 1 | Global direction returned from lookup time |
| up_lpred | input | 1 | Local direction returned from lookup time |

## Verification
On every cycle the assertions check the counter mechanics: saturation at both ends, no counter or history entry changing except at the written index, the history shift of the outcome, and that the output agrees with both components whenever they agree. Whether the right entry was indexed, whether the selector moved in the right direction for each right/wrong combination, and whether an update is visible one cycle later can only be shown by the bench. The bench compares every address against an arithmetic model after each update, across random outcomes, forced disagreement patterns, repeated saturation runs, loop-shaped patterns and idle cycles.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT  = 2'b01;
  localparam ctr2_t CTR_WEAK_TK  = 2'b10;

  // Saturating step of a 2-bit counter toward taken (up=1) or not taken.
  function automatic ctr2_t sat_step(input ctr2_t c, input logic up);
    ctr2_t r;
    if (up) r = (c == 2'd3) ? 2'd3 : c + 2'd1;
    else    r = (c == 2'd0) ? 2'd0 : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/tp_rst_sync.sv
module tp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/tp_ctr_table.sv
module tp_ctr_table import tp_pkg::*; #(
  parameter int    IDX_W   = 4,
  parameter ctr2_t RST_VAL = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t            cnt_q [DEPTH];
  ctr2_t            cnt_d [DEPTH];
  logic [DEPTH-1:0] ent_en;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_en[i] = wr_en && (wr_idx == IDX_W'(i));
      cnt_d[i]  = sat_step(cnt_q[i], wr_up);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_en[i]) cnt_q[i] <= cnt_d[i];
      end
    end
  end

  assign rd_msb = cnt_q[rd_idx][1];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(g) && wr_up && cnt_q[g] == 2'd3) |=> (cnt_q[g] == 2'd3)); // R2
      AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(g) && !wr_up && cnt_q[g] == 2'd0) |=> (cnt_q[g] == 2'd0)); // R2
      AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(cnt_q[g])); // R7
    end
  endgenerate

endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit,
  output logic [HIST_W-1:0] wr_hist
);

  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];
  logic [HIST_W-1:0] hist_d [DEPTH];
  logic [DEPTH-1:0]  ent_en;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_en[i] = wr_en && (wr_idx == IDX_W'(i));
      hist_d[i] = {hist_q[i][HIST_W-2:0], wr_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_en[i]) hist_q[i] <= hist_d[i];
      end
    end
  end

  assign rd_hist = hist_q[rd_idx];
  assign wr_hist = hist_q[wr_idx];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      AST_LHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(g)) |=>
          (hist_q[g][0] == $past(wr_bit) &&
           hist_q[g][HIST_W-1:1] == $past(hist_q[g][HIST_W-2:0]))); // R4
      AST_LHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(hist_q[g])); // R7
    end
  endgenerate

endmodule

// File: rtl/tourney_pred.sv
module tourney_pred import tp_pkg::*; #(
  parameter int PC_W   = 4,
  parameter int LHIST_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_final,
  output logic            lk_gpred,
  output logic            lk_lpred,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_gpred,
  input  logic            up_lpred
);

  localparam int GHIST_W = PC_W;

  logic               rst_i_n;
  logic [GHIST_W-1:0] ghist_q;
  logic [GHIST_W-1:0] ghist_d;
  logic [LHIST_W-1:0] lk_lhist;
  logic [LHIST_W-1:0] up_lhist;
  logic               sel_global;
  logic               g_ok;
  logic               l_ok;
  logic               ch_we;

  tp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Global history: outcome enters at bit 0.
  always_comb ghist_d = {ghist_q[GHIST_W-2:0], up_taken};

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)      ghist_q <= '0;
    else if (up_valid) ghist_q <= ghist_d;
  end

  tp_ctr_table #(.IDX_W(GHIST_W), .RST_VAL(CTR_WEAK_NT)) u_gpht (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .rd_idx (ghist_q ^ lk_pc),
    .rd_msb (lk_gpred),
    .wr_en  (up_valid),
    .wr_idx (ghist_q ^ up_pc),
    .wr_up  (up_taken)
  );

  tp_hist_table #(.IDX_W(PC_W), .HIST_W(LHIST_W)) u_lht (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .rd_idx  (lk_pc),
    .rd_hist (lk_lhist),
    .wr_en   (up_valid),
    .wr_idx  (up_pc),
    .wr_bit  (up_taken),
    .wr_hist (up_lhist)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .RST_VAL(CTR_WEAK_NT)) u_lpht (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .rd_idx (lk_lhist),
    .rd_msb (lk_lpred),
    .wr_en  (up_valid),
    .wr_idx (up_lhist),
    .wr_up  (up_taken)
  );

  // Selector trains only when exactly one component was right.
  always_comb begin
    g_ok  = (up_gpred == up_taken);
    l_ok  = (up_lpred == up_taken);
    ch_we = up_valid && (g_ok != l_ok);
  end

  tp_ctr_table #(.IDX_W(PC_W), .RST_VAL(CTR_WEAK_TK)) u_chooser (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .rd_idx (lk_pc),
    .rd_msb (sel_global),
    .wr_en  (ch_we),
    .wr_idx (up_pc),
    .wr_up  (g_ok)
  );

  assign lk_final = sel_global ? lk_gpred : lk_lpred;

  AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_i_n)
    up_valid |=> (ghist_q[0] == $past(up_taken))); // R3
  AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    !up_valid |=> $stable(ghist_q)); // R7
  AST_FINAL_AGREE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (lk_gpred == lk_lpred) |-> (lk_final == lk_gpred)); // R5

endmodule

// File: tb/tb_tourney_pred.sv
`timescale 1ns/1ps
module tb_tourney_pred;

  localparam int PC_W  = 4;
  localparam int LH_W  = 4;
  localparam int NPC   = 1 << PC_W;
  localparam int NLP   = 1 << LH_W;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PC_W-1:0] lk_pc;
  logic            lk_final, lk_gpred, lk_lpred;
  logic            up_valid;
  logic [PC_W-1:0] up_pc;
  logic            up_taken, up_gpred, up_lpred;

  int vec_cnt = 0;
  int err_cnt = 0;
  logic [31:0] rng = 32'h1bad_5eed;

  // Reference state
  logic [1:0]      m_gpht [NPC];
  logic [1:0]      m_lpht [NLP];
  logic [LH_W-1:0] m_lht  [NPC];
  logic [1:0]      m_ch   [NPC];
  logic [PC_W-1:0] m_gh;

  always #5 clk = ~clk;

  tourney_pred #(.PC_W(PC_W), .LHIST_W(LH_W)) dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_final(lk_final),
    .lk_gpred(lk_gpred), .lk_lpred(lk_lpred), .up_valid(up_valid),
    .up_pc(up_pc), .up_taken(up_taken), .up_gpred(up_gpred), .up_lpred(up_lpred)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [1:0] step2(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  function automatic logic exp_g(input logic [PC_W-1:0] pc);
    return m_gpht[m_gh ^ pc][1];
  endfunction
  function automatic logic exp_l(input logic [PC_W-1:0] pc);
    return m_lpht[m_lht[pc]][1];
  endfunction
  function automatic logic exp_f(input logic [PC_W-1:0] pc);
    return m_ch[pc][1] ? exp_g(pc) : exp_l(pc);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NPC; i++) begin
      m_gpht[i] = 2'b01; m_lht[i] = '0; m_ch[i] = 2'b10;
    end
    for (int i = 0; i < NLP; i++) m_lpht[i] = 2'b01;
    m_gh = '0;
  endtask

  task automatic model_update(input logic [PC_W-1:0] pc, input logic tk,
                              input logic gp, input logic lp);
    logic gi_ok, li_ok;
    m_gpht[m_gh ^ pc]  = step2(m_gpht[m_gh ^ pc], tk);
    m_lpht[m_lht[pc]]  = step2(m_lpht[m_lht[pc]], tk);
    gi_ok = (gp == tk);
    li_ok = (lp == tk);
    if (gi_ok && !li_ok) m_ch[pc] = step2(m_ch[pc], 1'b1);
    if (li_ok && !gi_ok) m_ch[pc] = step2(m_ch[pc], 1'b0);
    m_lht[pc] = {m_lht[pc][LH_W-2:0], tk};
    m_gh      = {m_gh[PC_W-2:0], tk};
  endtask

  // Lookup every address against the model; called in the low clock phase.
  task automatic sweep(input string tag);
    for (int p = 0; p < NPC; p++) begin
      lk_pc = PC_W'(p);
      #0.2;
      chk({tag, " R3 global"}, lk_gpred, exp_g(PC_W'(p)));
      chk({tag, " R4 local"},  lk_lpred, exp_l(PC_W'(p)));
      chk({tag, " R5 final"},  lk_final, exp_f(PC_W'(p)));
    end
  endtask

  // One resolved branch. force_p=1 returns arbitrary component directions.
  task automatic branch(input logic [PC_W-1:0] pc, input logic tk,
                        input logic force_p, input string tag);
    logic gp, lp;
    lk_pc = pc;
    #0.2;
    chk({tag, " R8 lookup g"}, lk_gpred, exp_g(pc));
    chk({tag, " R8 lookup l"}, lk_lpred, exp_l(pc));
    gp = lk_gpred;
    lp = lk_lpred;
    if (force_p) begin
      rng = next_rand(rng);
      gp  = rng[3];
      lp  = rng[9];
    end
    up_valid = 1'b1; up_pc = pc; up_taken = tk; up_gpred = gp; up_lpred = lp;
    @(posedge clk);
    model_update(pc, tk, gp, lp);
    @(negedge clk);
    up_valid = 1'b0;
    sweep({tag, " R6 R7"});
  endtask

  task automatic idle_cycle();
    rng = next_rand(rng);
    up_valid = 1'b0; up_pc = rng[PC_W-1:0]; up_taken = rng[5];
    up_gpred = rng[6]; up_lpred = rng[7];
    @(posedge clk);
    @(negedge clk);
    sweep("R7 idle");
  endtask

  logic finished = 1'b0;

  initial begin
    #(200000 * 10);
    if (!finished) begin
      err_cnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_pc = '0; up_valid = 1'b0; up_pc = '0;
    up_taken = 1'b0; up_gpred = 1'b0; up_lpred = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    sweep("R1 reset");

    // R2: drive one address to saturation both ways
    for (int k = 0; k < 6; k++) branch(4'd5, 1'b1, 1'b0, "R2 sat up");
    for (int k = 0; k < 6; k++) branch(4'd5, 1'b0, 1'b0, "R2 sat down");

    // Random outcomes with real component directions
    for (int k = 0; k < 200; k++) begin
      rng = next_rand(rng);
      branch(rng[PC_W-1:0], rng[11], 1'b0, "rand");
      if (k % 7 == 3) idle_cycle();
    end

    // R6: arbitrary right/wrong combinations
    for (int k = 0; k < 120; k++) begin
      rng = next_rand(rng);
      branch(rng[PC_W+1:2], rng[13], 1'b1, "R6 forced");
    end

    // Loop-shaped outcome patterns on a few addresses
    for (int k = 0; k < 120; k++)
      branch(PC_W'(k % 4), (k % 5) != 4, 1'b0, "loop");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule